// File: doc/BRIEF.md
# Infrared Pulse Modem with Baud Divider

This block sits between a UART's serial pins and an infrared transceiver. A programmable 12-bit divider turns the system clock into a one-cycle enable at sixteen times the bit rate. The transmit and receive paths share that enable, and it is also given to the UART so that it can pace its own framing.

In infrared mode the transmit path sends a zero bit as a short high pulse that lasts three of the sixteen ticks of a bit. A one bit sends nothing. The receive path synchronises the incoming pulse line and detects each rising edge. Each edge holds the NRZ output low for sixteen ticks, which rebuilds a zero bit. A bit period with no pulse leaves the output high.

When infrared mode is off, both directions pass plain NRZ straight through without any clock delay.

Top module: `irda_pulse_modem`

## Requirements
- R1: After a synchronous active-low reset, `baud_tick` is low, `tx_ir_out` is low in infrared mode and `rx_nrz_out` is high in infrared mode.
- R2: With a divider value N from 1 to 4095, `baud_tick` is high for one clock and then low for N clocks, repeating every N+1 clocks. The first tick comes N+1 clocks after reset is released.
- R3: A divider value of 0 makes `baud_tick` high on every clock from the first clock after reset.
- R4: A bit period is 16 consecutive ticks, counted from the first tick after reset. In infrared mode, if `tx_nrz_in` is 0 at the first tick of a bit period, `tx_ir_out` goes high in the clock after that tick and stays high for exactly 3 tick intervals. It drops in the clock after the fourth tick of the period.
- R5: In infrared mode, if `tx_nrz_in` is 1 at the first tick of a bit period, `tx_ir_out` stays low for the whole period.
- R6: In infrared mode, a rising edge on `rx_ir_in` passes through two synchroniser flops and an edge detector. `rx_nrz_out` goes low 3 clocks after the edge. It stays low until 16 ticks have been consumed, and then returns high.
- R7: A new rising edge on `rx_ir_in` while `rx_nrz_out` is already low restarts the 16-tick hold.
- R8: With `ir_mode` = 0, `tx_ir_out` equals `tx_nrz_in` and `rx_nrz_out` equals `rx_ir_in` in the same cycle.
- R9: Changes of `tx_nrz_in` at any tick other than the first of a bit period have no effect on `tx_ir_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_value | input | 12 | Divider setting; divides by value + 1 |
| ir_mode | input | 1 | 1 = infrared pulse coding, 0 = NRZ bypass |
| tx_nrz_in | input | 1 | NRZ transmit data from the UART |
| tx_ir_out | output | 1 | Pulse (or NRZ) output toward the LED driver |
| rx_ir_in | input | 1 | Active-high pulse (or NRZ) input from the receiver front end |
| rx_nrz_out | output | 1 | Rebuilt NRZ receive data toward the UART |
| baud_tick | output | 1 | One-cycle enable at 16x the bit rate |

## Verification
The assertions assume that `div_value` is a static value that changes only from one whole cycle to the next, and that `rx_ir_in` returns low between pulses, so that each pulse gives a separate rising edge after synchronisation. The stimulus changes the divider only at segment boundaries and always inserts at least one low cycle after a receive pulse. Transmit data changes at random cycles, including in the middle of bit periods, so that the bench can confirm that only the value present at the first tick of a period matters. Receive pulses come often enough to overlap running holds and sparsely enough to let holds expire.

// File: rtl/irda_modem_pkg.sv
// Shared constants and the link-mode encoding for the infrared pulse modem.
package irda_modem_pkg;
    localparam int unsigned OVERSAMPLE  = 16;  // ticks per bit period
    localparam int unsigned PULSE_TICKS = 3;   // ticks of a zero-bit pulse
    typedef enum logic {
        MODE_NRZ = 1'b0,
        MODE_IR  = 1'b1
    } link_mode_e;
endpackage

// File: rtl/baud_tick_gen.sv
// Programmable divider producing a one-cycle oversample tick.
// Assumes div_value is static relative to clk; a value N divides by N+1.
module baud_tick_gen #(
    parameter int unsigned DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_value,
    output logic             tick
);
    logic [DIV_W-1:0] count_q;

    // Count up to the divider value, then wrap and emit a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            tick    <= 1'b0;
        end else if (count_q >= div_value) begin
            count_q <= '0;
            tick    <= 1'b1;
        end else begin
            count_q <= count_q + 1'b1;
            tick    <= 1'b0;
        end
    end

    // R3: a zero setting ticks every cycle.
    assert_div_zero_every_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_value == '0) |=> tick);

    // R2: with a nonzero setting, a tick is never followed directly by another.
    assert_tick_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_value != '0) |=> !tick);
endmodule

// File: rtl/ir_tx_shaper.sv
// Converts NRZ transmit data into short pulses: a zero bit gives a pulse
// lasting PULSE_TICKS of the OVERSAMPLE ticks of a bit, and a one bit gives none.
// Assumes tick is a one-cycle enable. The bit value is sampled only at the
// first tick of each bit period.
module ir_tx_shaper #(
    parameter int unsigned OVERSAMPLE  = 16,
    parameter int unsigned PULSE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic tx_bit,
    output logic pulse
);
    localparam int unsigned        PH_W      = $clog2(OVERSAMPLE);
    localparam logic [PH_W-1:0]    LAST_PH   = PH_W'(OVERSAMPLE - 1);
    localparam logic [PH_W-1:0]    PULSE_END = PH_W'(PULSE_TICKS);

    logic [PH_W-1:0] phase_q;

    // Track the position of the current tick within the bit period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (tick)
            phase_q <= (phase_q == LAST_PH) ? '0 : phase_q + 1'b1;
    end

    // Start a pulse for a zero bit at the first tick, and end it after PULSE_TICKS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse <= 1'b0;
        else if (tick && phase_q == '0)
            pulse <= ~tx_bit;
        else if (tick && phase_q == PULSE_END)
            pulse <= 1'b0;
    end

    // R5: a one bit sampled at the start of a period leaves the line dark.
    assert_one_bit_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && phase_q == '0 && tx_bit) |=> !pulse);

    // R4: a pulse only ends on a tick.
    assert_pulse_ends_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse) |-> $past(tick));

    // R4: a pulse never extends past the early part of the bit period.
    assert_pulse_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (phase_q >= 1 && phase_q <= PULSE_END));
endmodule

// File: rtl/ir_rx_stretcher.sv
// Rebuilds NRZ from active-high receive pulses. The input is synchronised
// with two flops, and each rising edge holds the output low for OVERSAMPLE ticks.
// Assumes pulses return low between bits, so that each bit gives a separate edge.
module ir_rx_stretcher #(
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ir_pulse_in,
    output logic nrz
);
    localparam int unsigned     CW       = $clog2(OVERSAMPLE + 1);
    localparam logic [CW-1:0]   HOLD_MAX = CW'(OVERSAMPLE);

    logic [2:0]    sync_q;
    logic [CW-1:0] hold_q;
    logic          rise;

    // Two synchroniser stages followed by one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= '0;
        else
            sync_q <= {sync_q[1:0], ir_pulse_in};
    end

    assign rise = sync_q[1] & ~sync_q[2];

    // Load the hold counter on an edge, and count it down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (rise)
            hold_q <= HOLD_MAX;
        else if (tick && hold_q != '0)
            hold_q <= hold_q - 1'b1;
    end

    assign nrz = (hold_q == '0);

    // R6: a detected edge forces the rebuilt data low in the next cycle.
    assert_edge_pulls_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !nrz);

    // R6: the output is released only when a tick is consumed.
    assert_release_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nrz) |-> $past(tick));
endmodule

// File: rtl/irda_pulse_modem.sv
// Top level: the baud divider, the pulse shaper, the pulse stretcher and the
// NRZ bypass. Assumes ir_mode and div_value are synchronous to clk.
module irda_pulse_modem
    import irda_modem_pkg::*;
#(
    parameter int unsigned DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_value,
    input  logic             ir_mode,
    input  logic             tx_nrz_in,
    output logic             tx_ir_out,
    input  logic             rx_ir_in,
    output logic             rx_nrz_out,
    output logic             baud_tick
);
    logic tx_pulse;
    logic rx_rebuilt;

    baud_tick_gen #(.DIV_W(DIV_W)) div_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_value (div_value),
        .tick      (baud_tick)
    );

    ir_tx_shaper #(.OVERSAMPLE(OVERSAMPLE), .PULSE_TICKS(PULSE_TICKS)) tx_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (baud_tick),
        .tx_bit (tx_nrz_in),
        .pulse  (tx_pulse)
    );

    ir_rx_stretcher #(.OVERSAMPLE(OVERSAMPLE)) rx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (baud_tick),
        .ir_pulse_in (rx_ir_in),
        .nrz         (rx_rebuilt)
    );

    // Select the coded path or the plain NRZ bypass for each direction.
    assign tx_ir_out  = (ir_mode == MODE_IR) ? tx_pulse   : tx_nrz_in;
    assign rx_nrz_out = (ir_mode == MODE_IR) ? rx_rebuilt : rx_ir_in;
endmodule

// File: tb/irda_pulse_modem_tb_top.sv
`timescale 1ns/1ps
module irda_pulse_modem_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] div_value = '0;
    logic        ir_mode = 1'b1;
    logic        tx_nrz_in = 1'b1;
    logic        rx_ir_in = 1'b0;
    logic        tx_ir_out, rx_nrz_out, baud_tick;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    // Reference model state, derived from the requirements.
    int m_cnt = 0, m_tick = 0, m_phase = 0, m_pulse = 0, m_bit = 1;
    int s1 = 0, s2 = 0, s3 = 0, m_hold = 0;
    int rx_left = 0;

    irda_pulse_modem dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_value  (div_value),
        .ir_mode    (ir_mode),
        .tx_nrz_in  (tx_nrz_in),
        .tx_ir_out  (tx_ir_out),
        .rx_ir_in   (rx_ir_in),
        .rx_nrz_out (rx_nrz_out),
        .baud_tick  (baud_tick)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Compare the outputs with the model, then advance the model by one clock.
    task automatic check_and_step();
        int edge_m;
        check(32'(baud_tick) == m_tick, (div_value == 0) ? "R3 tick" : "R2 tick",
              32'(baud_tick), m_tick);
        if (ir_mode) begin
            check(32'(tx_ir_out) == m_pulse, (m_bit == 0) ? "R4 R9 tx" : "R5 R9 tx",
                  32'(tx_ir_out), m_pulse);
            check(32'(rx_nrz_out) == (m_hold == 0 ? 1 : 0), "R6 R7 rx",
                  32'(rx_nrz_out), (m_hold == 0 ? 1 : 0));
        end else begin
            check(tx_ir_out == tx_nrz_in, "R8 tx bypass", 32'(tx_ir_out), 32'(tx_nrz_in));
            check(rx_nrz_out == rx_ir_in, "R8 rx bypass", 32'(rx_nrz_out), 32'(rx_ir_in));
        end
        edge_m = s2 & ~s3;
        if (edge_m != 0) m_hold = 16;
        else if (m_tick != 0 && m_hold > 0) m_hold--;
        s3 = s2; s2 = s1; s1 = 32'(rx_ir_in);
        if (m_tick != 0) begin
            if (m_phase == 0) begin
                m_pulse = tx_nrz_in ? 0 : 1;
                m_bit = 32'(tx_nrz_in);
            end else if (m_phase == 3) begin
                m_pulse = 0;
            end
            m_phase = (m_phase + 1) % 16;
        end
        if (m_cnt >= int'(div_value)) begin
            m_cnt = 0; m_tick = 1;
        end else begin
            m_cnt++; m_tick = 0;
        end
    endtask

    // Choose the next input values with rates scaled to the bit period.
    task automatic drive_next();
        int scale = int'(div_value) + 1;
        if (($urandom % (8 * scale)) == 0) tx_nrz_in = ~tx_nrz_in;
        if (rx_left > 0) begin
            rx_left--;
            rx_ir_in = (rx_left > 0);
        end else if (($urandom % (10 * scale)) == 0) begin
            rx_left = 1 + int'($urandom % 4);
            rx_ir_in = 1'b1;
        end else begin
            rx_ir_in = 1'b0;
        end
    endtask

    task automatic run_segment(input int div, input bit mode, input int n);
        div_value = 12'(div);
        ir_mode = mode;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_and_step();
            @(posedge clk);
            #1;
            drive_next();
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state before any clock has been consumed.
        check(baud_tick == 1'b0, "R1 tick", 32'(baud_tick), 0);
        check(tx_ir_out == 1'b0, "R1 tx", 32'(tx_ir_out), 0);
        check(rx_nrz_out == 1'b1, "R1 rx", 32'(rx_nrz_out), 1);
        check_and_step();
        @(posedge clk);
        #1;
        run_segment(0, 1'b1, 3000);
        run_segment(1, 1'b1, 4000);
        run_segment(2, 1'b1, 5000);
        run_segment(3, 1'b0, 2000);
        run_segment(5, 1'b1, 8000);
        run_segment(8, 1'b1, 10000);
        run_segment(15, 1'b1, 12000);
        run_segment(8, 1'b0, 2000);
        run_segment(255, 1'b1, 40000);
        run_segment(4095, 1'b1, 20000);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule